// File: doc/BRIEF.md
# Configuration Load Sequencer

This block steers a programmable device from a global reset to the end of bitstream loading. It runs its phases in a fixed order. First it clears configuration memory while it pulls the shared init line low. It then waits for that line to read high and latches the mode pins at that moment. Next it hunts the incoming 32-bit word stream for the synchronization pattern. The word after that pattern must equal the device identity, and a word count follows it. The block then passes the counted data words out on a frame write port, checks a CRC-32 word against those data words, and finishes with a short startup countdown before it raises done.

The init line is open-drain, so it appears here as two halves: the level read back from the pad and a pull-low enable. Before the mode pins are latched, an external agent can hold the line low to stall the sequence. After that point the block pulls the line low only to report a CRC failure. The stream is consumed only during the synchronization, identity, count, data and CRC phases. Words that arrive in any other phase, or while the valid flag is low, have no effect. Command decoding is reduced to a fixed order: identity word, count word, data words, CRC word.

Top module: `cfg_load_seq`

## Requirements
- R1: While `prog_n` is low, `status` reads 0, `done` and `frame_we` are 0, and `init_pull_low` is 1. After `prog_n` returns high, the pull is released on the 18th rising clock edge: 2 edges of reset synchronization, then a memory-clear phase of 16 clocks.
- R2: Once the pull is released, the block stays in a waiting phase for as long as `init_line_in` reads low. No stream word is consumed and the mode field is not latched.
- R3: On the first rising edge at which `init_line_in` reads high after the release, `mode_pins` is latched into `status[7:5]`. Later changes on `mode_pins` do not alter that field. `status[4]` is 1 whenever the clear phase is over.
- R4: Before the mode pins are latched, and after that until the word 32'hAA995566 arrives with `cfg_valid` high, every word is ignored: `status[3]` stays 0 and `frame_we` stays 0. The synchronization word sets `status[3]`.
- R5: The valid word after synchronization is compared with the parameter `DEVICE_ID`. On a mismatch the block sets `status[2]` and halts, with no further frame writes, until `prog_n` goes low.
- R6: The next valid word is a count N. Each of the following N valid words produces a one-cycle `frame_we` pulse with `frame_data` equal to that word, visible in the clock cycle after the word is accepted. When N is 0 the block goes straight to the CRC word.
- R7: The valid word after the data words is compared with a CRC-32 over the data words. The CRC uses polynomial 0x04C11DB7, starts from all ones, takes each word MSB first, reflects nothing and applies no final XOR. On a mismatch `status[1]` is set and `init_pull_low` stays 1 until `prog_n` goes low.
- R8: On a CRC match, `done` and `status[0]` rise on the 8th rising edge after the edge that accepts the CRC word, and then stay high. Words that arrive after that are ignored.
- R9: A cycle with `cfg_valid` low consumes nothing in any phase.
- R10: Taking `prog_n` low at any point, including after an error, restarts the sequence with all status flags cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| prog_n | input | 1 | Asynchronous global reset, active low |
| init_line_in | input | 1 | Level read back from the open-drain init line |
| init_pull_low | output | 1 | Enables the pull-low driver of the init line |
| mode_pins | input | 3 | Mode pin levels |
| cfg_word | input | 32 | Configuration stream word |
| cfg_valid | input | 1 | Qualifies `cfg_word` |
| status | output | 8 | [7:5] mode, [4] init released, [3] synced, [2] ID error, [1] CRC error, [0] done |
| frame_we | output | 1 | Frame write strobe |
| frame_data | output | 32 | Word written with the strobe |
| done | output | 1 | Loading finished without error |

## Verification
A wrong phase shows at the ports within one clock of the next valid word. A phase that sits ahead of where it should be turns an ignored word into a `frame_we` pulse, or sets `status[3]` early. A phase that lags swallows a data word that should have produced a strobe. A miscounted word counter moves the CRC comparison by one word, so a good stream raises `status[1]` and pulls the init line low on the very next edge. An off-by-one in either countdown shifts the release of `init_pull_low` or the rise of `done` by one edge, and the edge-exact counts against R1 and R8 catch that shift.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    localparam int          WORD_W    = 32;
    localparam int          MODE_W    = 3;
    localparam logic [31:0] SYNC_WORD = 32'hAA99_5566;
    localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT  = 32'hFFFF_FFFF;

    typedef enum logic [3:0] {
        PH_CLEAR,
        PH_WAIT,
        PH_SYNC,
        PH_ID,
        PH_COUNT,
        PH_DATA,
        PH_CRC,
        PH_START,
        PH_DONE,
        PH_ERR
    } phase_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              init_rel;
        logic              synced;
        logic              id_err;
        logic              crc_err;
        logic              done;
    } cfg_status_t;

    // One 32-bit word folded into the CRC, most significant bit first.
    function automatic logic [31:0] crc32_word(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 31; i >= 0; i--) begin
            fb = r[31] ^ d[i];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain_q <= '0;
                else         chain_q <= 1'b1;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain_q <= '0;
                else         chain_q <= {chain_q[LAST-1:0], 1'b1};
            end
        end
    endgenerate

    assign rst_o = ~chain_q[LAST];
endmodule

// File: rtl/cfg_crc32_acc.sv
module cfg_crc32_acc
    import cfg_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              upd,
    input  logic [WORD_W-1:0] data,
    output logic [31:0]       crc
);
    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) crc_q <= CRC_INIT;
        else if (upd)   crc_q <= crc32_word(crc_q, data);
    end

    assign crc = crc_q;

    // R7: the running value moves only on a data word
    p_crc_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!upd && !clr) |=> $stable(crc_q));
endmodule

// File: rtl/cfg_phase_fsm.sv
module cfg_phase_fsm
    import cfg_seq_pkg::*;
#(
    parameter logic [31:0] DEVICE_ID    = 32'h0A5C_3E91,
    parameter int          CLEAR_CYCLES = 16,
    parameter int          START_CYCLES = 8,
    parameter int          CNT_W        = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_line,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic [WORD_W-1:0] word,
    input  logic              valid,
    input  logic [31:0]       crc_val,
    output logic              crc_clr,
    output logic              crc_upd,
    output logic              pull_low,
    output cfg_status_t       stat,
    output logic              we,
    output logic [WORD_W-1:0] wdata,
    output logic              done_o
);
    localparam int TICK_MAX = (CLEAR_CYCLES > START_CYCLES) ? CLEAR_CYCLES : START_CYCLES;
    localparam int TICK_W   = $clog2(TICK_MAX + 1);
    localparam logic [TICK_W-1:0] CLR_LAST = TICK_W'(CLEAR_CYCLES - 1);
    localparam logic [TICK_W-1:0] ST_LAST  = TICK_W'(START_CYCLES - 1);

    phase_e              ph_q;
    logic [TICK_W-1:0]   tick_q;
    logic [CNT_W-1:0]    wcnt_q;
    logic [MODE_W-1:0]   mode_q;
    logic                id_err_q, crc_err_q, synced_q, we_q;
    logic [WORD_W-1:0]   wdata_q;
    logic [CNT_W-1:0]    cnt_in;
    logic                mode_lock;

    assign cnt_in = word[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= PH_CLEAR;
            tick_q    <= '0;
            wcnt_q    <= '0;
            mode_q    <= '0;
            id_err_q  <= 1'b0;
            crc_err_q <= 1'b0;
            synced_q  <= 1'b0;
            we_q      <= 1'b0;
            wdata_q   <= '0;
        end else begin
            we_q <= 1'b0;
            unique case (ph_q)
                PH_CLEAR: begin
                    if (tick_q == CLR_LAST) begin
                        tick_q <= '0;
                        ph_q   <= PH_WAIT;
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (init_line) begin
                        mode_q <= mode_pins;
                        ph_q   <= PH_SYNC;
                    end
                end
                PH_SYNC: begin
                    if (valid && word == SYNC_WORD) begin
                        synced_q <= 1'b1;
                        ph_q     <= PH_ID;
                    end
                end
                PH_ID: begin
                    if (valid) begin
                        if (word == DEVICE_ID) ph_q <= PH_COUNT;
                        else begin
                            id_err_q <= 1'b1;
                            ph_q     <= PH_ERR;
                        end
                    end
                end
                PH_COUNT: begin
                    if (valid) begin
                        wcnt_q <= cnt_in;
                        ph_q   <= (cnt_in == '0) ? PH_CRC : PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (valid) begin
                        we_q    <= 1'b1;
                        wdata_q <= word;
                        wcnt_q  <= wcnt_q - 1'b1;
                        if (wcnt_q == CNT_W'(1)) ph_q <= PH_CRC;
                    end
                end
                PH_CRC: begin
                    if (valid) begin
                        if (word == crc_val) begin
                            tick_q <= '0;
                            ph_q   <= PH_START;
                        end else begin
                            crc_err_q <= 1'b1;
                            ph_q      <= PH_ERR;
                        end
                    end
                end
                PH_START: begin
                    if (tick_q == ST_LAST) ph_q <= PH_DONE;
                    else                   tick_q <= tick_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign crc_clr   = (ph_q == PH_COUNT);
    assign crc_upd   = (ph_q == PH_DATA) && valid;
    assign pull_low  = (ph_q == PH_CLEAR) || crc_err_q;
    assign mode_lock = (ph_q != PH_CLEAR) && (ph_q != PH_WAIT);
    assign done_o    = (ph_q == PH_DONE);
    assign we        = we_q;
    assign wdata     = wdata_q;

    always_comb begin
        stat          = '0;
        stat.mode     = mode_q;
        stat.init_rel = (ph_q != PH_CLEAR);
        stat.synced   = synced_q;
        stat.id_err   = id_err_q;
        stat.crc_err  = crc_err_q;
        stat.done     = done_o;
    end

    // R6: frame writes only after synchronization
    p_we_after_sync_r6: assert property (@(posedge clk) disable iff (rst)
        we_q |-> synced_q);
    // R5: identity and CRC errors never coexist
    p_err_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(id_err_q && crc_err_q));
    // R5: identity error is sticky
    p_id_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        id_err_q |=> id_err_q);
    // R7: CRC error is sticky and keeps the pull
    p_crc_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        crc_err_q |=> (crc_err_q && pull_low));
    // R3: latched mode frozen after sampling
    p_mode_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_lock && $past(mode_lock)) |-> $stable(mode_q));
    // R8: done only on a clean load, and it stays
    p_done_clean_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!crc_err_q && !id_err_q));
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o);
endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
    import cfg_seq_pkg::*;
#(
    parameter logic [31:0] DEVICE_ID    = 32'h0A5C_3E91,
    parameter int          CLEAR_CYCLES = 16,
    parameter int          START_CYCLES = 8,
    parameter int          CNT_W        = 32,
    parameter int          RST_STAGES   = 2
) (
    input  logic        clk,
    input  logic        prog_n,
    input  logic        init_line_in,
    output logic        init_pull_low,
    input  logic [2:0]  mode_pins,
    input  logic [31:0] cfg_word,
    input  logic        cfg_valid,
    output logic [7:0]  status,
    output logic        frame_we,
    output logic [31:0] frame_data,
    output logic        done
);
    logic        rst;
    logic        crc_clr, crc_upd;
    logic [31:0] crc_val;
    cfg_status_t stat;

    cfg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
        .clk    (clk),
        .arst_n (prog_n),
        .rst_o  (rst)
    );

    cfg_crc32_acc u_crc (
        .clk  (clk),
        .rst  (rst),
        .clr  (crc_clr),
        .upd  (crc_upd),
        .data (cfg_word),
        .crc  (crc_val)
    );

    cfg_phase_fsm #(
        .DEVICE_ID    (DEVICE_ID),
        .CLEAR_CYCLES (CLEAR_CYCLES),
        .START_CYCLES (START_CYCLES),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .init_line (init_line_in),
        .mode_pins (mode_pins),
        .word      (cfg_word),
        .valid     (cfg_valid),
        .crc_val   (crc_val),
        .crc_clr   (crc_clr),
        .crc_upd   (crc_upd),
        .pull_low  (init_pull_low),
        .stat      (stat),
        .we        (frame_we),
        .wdata     (frame_data),
        .done_o    (done)
    );

    assign status = stat;

    // R1: reset keeps the line pulled and nothing written
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) && rst |-> (!frame_we && !done && init_pull_low));
endmodule

// File: tb/sim_cfg_load_seq.sv
module sim_cfg_load_seq;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] DEV_ID     = 32'h1D0C_7A53;
    localparam logic [31:0] SYNC       = 32'hAA99_5566;

    // {seed, n, mode, bad_id, bad_crc, gaps, exp{id_err,crc_err,done}, pad}
    localparam logic [47:0] VEC [6] = '{
        {32'h1234_5678, 4'd3, 3'b101, 1'b0, 1'b0, 1'b0, 3'b001, 3'b000},
        {32'hDEAD_BEEF, 4'd1, 3'b011, 1'b0, 1'b0, 1'b1, 3'b001, 3'b000},
        {32'h0000_0000, 4'd0, 3'b000, 1'b0, 1'b0, 1'b0, 3'b001, 3'b000},
        {32'hCAFE_F00D, 4'd4, 3'b110, 1'b0, 1'b1, 1'b1, 3'b010, 3'b000},
        {32'h5555_AAAA, 4'd2, 3'b111, 1'b1, 1'b0, 1'b0, 3'b100, 3'b000},
        {32'hFFFF_FFFF, 4'd7, 3'b001, 1'b0, 1'b0, 1'b1, 3'b001, 3'b000}
    };

    logic        clk = 1'b0;
    logic        prog_n = 1'b1;
    logic        ext_hold = 1'b0;
    logic [2:0]  mode_pins = 3'b000;
    logic [31:0] cfg_word = 32'h0;
    logic        cfg_valid = 1'b0;
    logic        init_pull_low, frame_we, done;
    logic [7:0]  status;
    logic [31:0] frame_data;
    logic        init_line;
    int          checks = 0;
    int          errors = 0;

    assign init_line = !(init_pull_low || ext_hold);

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_load_seq #(.DEVICE_ID(DEV_ID)) u0 (
        .clk          (clk),
        .prog_n       (prog_n),
        .init_line_in (init_line),
        .init_pull_low(init_pull_low),
        .mode_pins    (mode_pins),
        .cfg_word     (cfg_word),
        .cfg_valid    (cfg_valid),
        .status       (status),
        .frame_we     (frame_we),
        .frame_data   (frame_data),
        .done         (done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r = c;
        for (int b = 31; b >= 0; b--)
            r = (r << 1) ^ ({32{r[31] ^ d[b]}} & 32'h04C1_1DB7);
        return r;
    endfunction

    function automatic logic [31:0] dword(input logic [31:0] seed, input int i);
        return seed ^ (32'(i + 1) * 32'h9E37_79B9);
    endfunction

    // drive one word at a falling edge; returns at the next falling edge
    task automatic send(input logic [31:0] w, input logic v);
        cfg_word  = w;
        cfg_valid = v;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    // reset pulse, checks R1/R10 state, leaves prog_n released
    task automatic do_reset(input string tag);
        @(negedge clk);
        prog_n = 1'b0;
        cfg_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk({tag, " status"}, 32'(status), 32'h0);
        chk({tag, " done"}, 32'(done), 32'h0);
        chk({tag, " we"}, 32'(frame_we), 32'h0);
        chk({tag, " pull"}, 32'(init_pull_low), 32'h1);
        prog_n = 1'b1;
    endtask

    // returns count of rising edges until the pull is released
    task automatic wait_release(output int n);
        n = 0;
        while (init_pull_low && n < 100) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int n;
        logic [31:0] crc;
        #1 prog_n = 1'b0;

        // ---- vector table ----
        for (int v = 0; v < 6; v++) begin
            logic [31:0] seed  = VEC[v][47:16];
            logic [3:0]  nw    = VEC[v][15:12];
            logic [2:0]  md    = VEC[v][11:9];
            logic        bid   = VEC[v][8];
            logic        bcrc  = VEC[v][7];
            logic        gaps  = VEC[v][6];
            logic [2:0]  expf  = VEC[v][5:3];
            mode_pins = md;
            do_reset("R10 reset");
            wait_release(n);
            chk("R1 release edge", 32'(n), 32'd18);
            @(negedge clk);
            chk("R3 mode latched", 32'(status[7:5]), 32'(md));
            chk("R3 init released", 32'(status[4]), 32'h1);
            send(DEV_ID, 1'b1);
            send(32'hAA99_5567, 1'b1);
            send(SYNC, 1'b0);
            chk("R4 junk ignored sync", 32'(status[3]), 32'h0);
            chk("R9 invalid sync ignored", 32'(frame_we), 32'h0);
            send(SYNC, 1'b1);
            chk("R4 synced", 32'(status[3]), 32'h1);
            send(bid ? DEV_ID ^ 32'h1 : DEV_ID, 1'b1);
            if (bid) begin
                chk("R5 id err", 32'(status[2]), 32'h1);
                send(32'd2, 1'b1);
                send(32'h1111_1111, 1'b1);
                chk("R5 halted no write", 32'(frame_we), 32'h0);
                send(32'h2222_2222, 1'b1);
                chk("R5 halted no write 2", 32'(frame_we), 32'h0);
            end else begin
                send(32'(nw), 1'b1);
                chk("R6 count no write", 32'(frame_we), 32'h0);
                crc = 32'hFFFF_FFFF;
                for (int i = 0; i < int'(nw); i++) begin
                    if (gaps) begin
                        send(32'hBAD0_0000 | 32'(i), 1'b0);
                        chk("R9 gap no write", 32'(frame_we), 32'h0);
                    end
                    send(dword(seed, i), 1'b1);
                    chk("R6 we", 32'(frame_we), 32'h1);
                    chk("R6 data", frame_data, dword(seed, i));
                    crc = ref_crc(crc, dword(seed, i));
                end
                send(bcrc ? ~crc : crc, 1'b1);
                chk("R6 crc word no write", 32'(frame_we), 32'h0);
                if (bcrc) begin
                    chk("R7 crc err", 32'(status[1]), 32'h1);
                    chk("R7 pull low", 32'(init_pull_low), 32'h1);
                    repeat (5) @(negedge clk);
                    chk("R7 pull held", 32'(init_pull_low), 32'h1);
                end else begin
                    n = 0;
                    while (!done && n < 30) begin
                        @(posedge clk);
                        n++;
                        @(negedge clk);
                    end
                    chk("R8 done edge", 32'(n), 32'd8);
                    send(SYNC, 1'b1);
                    send(32'h0123_4567, 1'b1);
                    chk("R8 post-done ignored", 32'(frame_we), 32'h0);
                    chk("R8 done held", 32'(done), 32'h1);
                end
            end
            chk("R5 R7 R8 flags", 32'(status[2:0]), 32'(expf));
        end

        // ---- directed: external hold before mode sampling ----
        mode_pins = 3'b010;
        ext_hold  = 1'b1;
        do_reset("R1 reset");
        repeat (40) @(negedge clk);
        chk("R2 pull released", 32'(init_pull_low), 32'h0);
        chk("R2 init released bit", 32'(status[4]), 32'h1);
        chk("R2 mode not latched", 32'(status[7:5]), 32'h0);
        send(SYNC, 1'b1);
        chk("R4 sync ignored during hold", 32'(status[3]), 32'h0);
        mode_pins = 3'b110;
        ext_hold  = 1'b0;
        @(negedge clk);
        chk("R3 mode at line high", 32'(status[7:5]), 32'h6);
        mode_pins = 3'b001;
        repeat (3) @(negedge clk);
        chk("R3 mode frozen", 32'(status[7:5]), 32'h6);

        // ---- directed: reset in the middle of data ----
        send(SYNC, 1'b1);
        send(DEV_ID, 1'b1);
        send(32'd5, 1'b1);
        send(32'hAAAA_0001, 1'b1);
        chk("R6 mid we", 32'(frame_we), 32'h1);
        send(32'hAAAA_0002, 1'b1);
        do_reset("R10 mid-load reset");
        wait_release(n);
        chk("R10 restart release", 32'(n), 32'd18);
        @(negedge clk);
        send(32'hAAAA_0003, 1'b1);
        chk("R10 no stale write", 32'(frame_we), 32'h0);
        chk("R10 not synced", 32'(status[3]), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule